// File: doc/BRIEF.md
# Predicated FP Immediate Vector Broadcast

This block decodes one 32-bit vector instruction word, the predicated form that copies a floating-point immediate into a vector. It expands the 8-bit immediate into a half-, single- or double-precision constant. It then merges that constant into the current contents of the destination vector under a governing predicate. Lanes whose predicate bit is set take the constant. All other lanes keep their old value.

The caller presents the instruction word, the old destination vector and the predicate together with a one-cycle `in_valid` strobe. One clock later the block returns the merged vector, a one-cycle `out_valid` pulse, a flag for the reserved lane-width encoding, and the destination and predicate register indices. The vector length `VLEN` is a parameter and must be a multiple of 128 bits. The predicate carries one bit per byte of the vector.

Top module: `vfimm_merge`

## Requirements
- R1: `out_valid` pulses one cycle after `in_valid` only when the word has bits [31:24] = 00000101, bits [21:20] = 01 and bits [15:13] = 110. For any other word, and in any cycle without `in_valid`, `out_valid` stays low.
- R2: With each accepted word, `dst_idx` reports bits [4:0] and `pred_idx` reports bits [19:16].
- R3: If the lane-width field at bits [23:22] is 00, the block raises `out_undef` together with `out_valid`, and `result` equals the old vector.
- R4: The lane-width field values 01, 10 and 11 select 16-, 32- and 64-bit lanes, and the block processes VLEN/lane-width lanes.
- R5: The immediate at bits [12:5] expands as follows. The sign is imm[7]. The exponent is ~imm[6], then imm[6] repeated (E-3) times, then imm[5:4], with E = 5, 8 or 11. The fraction is imm[3:0] followed by zeros. For example, 0x70 gives 1.0, 0x00 gives 2.0 and 0xFF gives -1.9375.
- R6: A lane e takes the expanded constant when predicate bit e*(lane-width/8) is 1.
- R7: A lane whose governing predicate bit is 0 keeps its old value, and the other predicate bits in that lane's byte group have no effect. An all-zero predicate returns the old vector unchanged.
- R8: `result`, `dst_idx` and `pred_idx` hold their values in cycles without `in_valid`.
- R9: After reset, `out_valid`, `out_undef`, `result` and both indices are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word and operands present this cycle |
| instr | input | 32 | Instruction word |
| dst_old | input | VLEN | Current destination vector contents |
| pred | input | VLEN/8 | Governing predicate, one bit per byte |
| out_valid | output | 1 | Recognised word, result ready (one-cycle pulse) |
| out_undef | output | 1 | Reserved lane-width encoding seen |
| result | output | VLEN | Merged vector |
| dst_idx | output | 5 | Destination register index |
| pred_idx | output | 4 | Predicate register index |

## Verification
Every result is due exactly one clock edge after the edge that samples `in_valid`. On the following edge `out_valid` falls, while `result` and both indices stay put. The bench changes inputs on falling edges and reads outputs on the next falling edge, half a period after the registering edge. It reads them once more a full cycle later to confirm the pulse has ended and the data is held. Expected lane values come from hand-computed constants for each precision, merged by a bench-side lane walk driven by the predicate rule.

// File: rtl/vfimm_pkg.sv
package vfimm_pkg;

    localparam logic [7:0] OPC_HI  = 8'b0000_0101;
    localparam logic [1:0] OPC_MID = 2'b01;
    localparam logic [2:0] OPC_LO  = 3'b110;

    typedef enum logic [1:0] {
        SZ_RSVD   = 2'b00,
        SZ_HALF   = 2'b01,
        SZ_SINGLE = 2'b10,
        SZ_DOUBLE = 2'b11
    } lane_sz_e;

    typedef struct packed {
        logic     hit;
        logic     rsvd;
        lane_sz_e size;
        logic [3:0] pg;
        logic [7:0] imm;
        logic [4:0] zd;
    } dec_t;

endpackage

// File: rtl/vfimm_decode.sv
module vfimm_decode
    import vfimm_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    always_comb begin
        dec.hit  = (instr[31:24] == OPC_HI) && (instr[21:20] == OPC_MID)
                   && (instr[15:13] == OPC_LO);
        dec.size = lane_sz_e'(instr[23:22]);
        dec.rsvd = (instr[23:22] == SZ_RSVD);
        dec.pg   = instr[19:16];
        dec.imm  = instr[12:5];
        dec.zd   = instr[4:0];
    end
endmodule

// File: rtl/vfimm_expand.sv
module vfimm_expand #(
    parameter int EXPW  = 8,
    parameter int FRACW = 23,
    localparam int W    = 1 + EXPW + FRACW
) (
    input  logic [7:0]   imm8,
    output logic [W-1:0] fp_out
);
    // sign | ~b6, b6 repeated, b5:b4 | b3:b0, zero fill
    always_comb begin
        fp_out = {imm8[7], ~imm8[6], {(EXPW-3){imm8[6]}}, imm8[5:4],
                  imm8[3:0], {(FRACW-4){1'b0}}};
    end
endmodule

// File: rtl/vfimm_lane_merge.sv
module vfimm_lane_merge #(
    parameter int VLEN = 256,
    parameter int EW   = 32,
    localparam int NLANE = VLEN / EW,
    localparam int GRP   = EW / 8
) (
    input  logic [VLEN/8-1:0] pred,
    input  logic [VLEN-1:0]   old_vec,
    input  logic [EW-1:0]     fill,
    output logic [VLEN-1:0]   merged
);
    // only the lowest bit of each byte group steers a lane
    logic unused_pred_grp;
    assign unused_pred_grp = ^pred;

    for (genvar e = 0; e < NLANE; e++) begin : g_lane
        assign merged[e*EW +: EW] = pred[e*GRP] ? fill : old_vec[e*EW +: EW];
    end
endmodule

// File: rtl/vfimm_merge.sv
module vfimm_merge
    import vfimm_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [VLEN-1:0]   dst_old,
    input  logic [VLEN/8-1:0] pred,
    output logic              out_valid,
    output logic              out_undef,
    output logic [VLEN-1:0]   result,
    output logic [4:0]        dst_idx,
    output logic [3:0]        pred_idx
);
    typedef struct packed {
        logic            vld;
        logic            undef;
        logic [4:0]      zd;
        logic [3:0]      pg;
        logic [VLEN-1:0] vec;
    } st_t;

    dec_t            dec;
    logic [VLEN-1:0] cand [1:3];
    st_t             st_d, st_q;

    vfimm_decode i_dec (.instr(instr), .dec(dec));

    for (genvar g = 1; g <= 3; g++) begin : g_width
        localparam int EW   = 8 << g;
        localparam int EXPW = (g == 1) ? 5 : ((g == 2) ? 8 : 11);
        localparam int FRW  = EW - 1 - EXPW;
        logic [EW-1:0] konst;

        vfimm_expand #(.EXPW(EXPW), .FRACW(FRW)) i_exp (
            .imm8   (dec.imm),
            .fp_out (konst)
        );
        vfimm_lane_merge #(.VLEN(VLEN), .EW(EW)) i_mrg (
            .pred    (pred),
            .old_vec (dst_old),
            .fill    (konst),
            .merged  (cand[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.vld   = 1'b0;
        st_d.undef = 1'b0;
        if (in_valid) begin
            st_d.vld   = dec.hit;
            st_d.undef = dec.hit && dec.rsvd;
            st_d.zd    = dec.zd;
            st_d.pg    = dec.pg;
            st_d.vec   = dst_old;
            if (dec.hit) begin
                unique case (dec.size)
                    SZ_HALF:   st_d.vec = cand[1];
                    SZ_SINGLE: st_d.vec = cand[2];
                    SZ_DOUBLE: st_d.vec = cand[3];
                    default:   st_d.vec = dst_old;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_undef = st_q.undef;
    assign result    = st_q.vec;
    assign dst_idx   = st_q.zd;
    assign pred_idx  = st_q.pg;
endmodule

// File: rtl/vfimm_merge_chk.sv
module vfimm_merge_chk #(
    parameter int VLEN = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [31:0]       instr,
    input logic [VLEN-1:0]   dst_old,
    input logic [VLEN/8-1:0] pred,
    input logic              out_valid,
    input logic              out_undef,
    input logic [VLEN-1:0]   result,
    input logic [4:0]        dst_idx,
    input logic [3:0]        pred_idx
);
    logic fmt_ok;
    assign fmt_ok = (instr[31:24] == 8'b0000_0101) && (instr[21:20] == 2'b01)
                    && (instr[15:13] == 3'b110);

    a_r1_valid_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && fmt_ok |=> out_valid);

    a_r1_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r2_indices: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (dst_idx == $past(instr[4:0])) && (pred_idx == $past(instr[19:16])));

    a_r3_undef_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && fmt_ok && (instr[23:22] == 2'b00)
        |=> out_undef && (result == $past(dst_old)));

    a_r3_undef_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> out_valid);

    a_r7_zero_pred_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (pred == '0) |=> result == $past(dst_old));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(dst_idx) && $stable(pred_idx));
endmodule

bind vfimm_merge vfimm_merge_chk #(.VLEN(VLEN)) i_chk (.*);

// File: tb/test_vfimm_merge.sv
module test_vfimm_merge;
    localparam int VLEN = 256;
    localparam int PW   = VLEN / 8;

    typedef struct packed {
        logic [1:0]  sz;
        logic [7:0]  imm;
        logic [31:0] pr;
        logic [63:0] k;
    } vec_t;

    // expected constants worked out by hand from the expansion rule (R5)
    localparam vec_t TBL [12] = '{
        '{2'd1, 8'h70, 32'hFFFF_FFFF, 64'h3C00},
        '{2'd2, 8'h70, 32'hFFFF_FFFF, 64'h3F80_0000},
        '{2'd3, 8'h70, 32'hFFFF_FFFF, 64'h3FF0_0000_0000_0000},
        '{2'd1, 8'h00, 32'h5555_5555, 64'h4000},
        '{2'd2, 8'h00, 32'h1111_1111, 64'h4000_0000},
        '{2'd3, 8'h00, 32'h0101_0101, 64'h4000_0000_0000_0000},
        '{2'd1, 8'hFF, 32'h0000_F00F, 64'hBFC0},
        '{2'd2, 8'hFF, 32'h0000_00F1, 64'hBFF8_0000},
        '{2'd3, 8'hFF, 32'h0000_0101, 64'hBFFF_0000_0000_0000},
        '{2'd2, 8'h7F, 32'hEEEE_EEEE, 64'h3FF8_0000},
        '{2'd1, 8'h10, 32'h5A5A_5A5A, 64'h4400},
        '{2'd3, 8'h4C, 32'hFE01_00FF, 64'h3FCC_0000_0000_0000}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [31:0]     instr = '0;
    logic [VLEN-1:0] dst_old = '0;
    logic [PW-1:0]   pred = '0;
    logic            out_valid, out_undef;
    logic [VLEN-1:0] result;
    logic [4:0]      dst_idx;
    logic [3:0]      pred_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vfimm_merge #(.VLEN(VLEN)) i_vfimm_merge (.*);

    function automatic logic [31:0] mk_instr(logic [1:0] sz, logic [3:0] pg,
                                             logic [7:0] imm, logic [4:0] zd);
        return {8'b0000_0101, sz, 2'b01, pg, 3'b110, imm, zd};
    endfunction

    function automatic logic [VLEN-1:0] mk_old(int s);
        logic [VLEN-1:0] v;
        for (int w = 0; w < VLEN/32; w++) v[w*32 +: 32] = 32'hC0DE_0000 ^ (s << 8) ^ w;
        return v;
    endfunction

    function automatic logic [VLEN-1:0] exp_merge(logic [VLEN-1:0] old, logic [PW-1:0] p,
                                                  logic [1:0] sz, logic [63:0] k);
        logic [VLEN-1:0] v = old;
        int ew = 8 << sz;
        for (int e = 0; e < VLEN/ew; e++)
            if (p[e*ew/8])
                for (int b = 0; b < ew; b++) v[e*ew + b] = k[b];
        return v;
    endfunction

    task automatic chk(bit ok, string tag, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // inputs change on a falling edge; outputs read on the next falling edge
    task automatic apply(logic [31:0] ins, logic [PW-1:0] p, logic [VLEN-1:0] old);
        @(negedge clk);
        in_valid = 1'b1; instr = ins; pred = p; dst_old = old;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && out_undef == 0, "R9 flags after reset",
            {out_valid, out_undef}, 0);
        chk(result == '0, "R9 result after reset", result, '0);
        chk(dst_idx == 0 && pred_idx == 0, "R9 indices after reset",
            {dst_idx, pred_idx}, 0);
        rst_n = 1'b1;

        // table walk: R1 R4 R5 R6 R7
        for (int i = 0; i < 12; i++) begin
            logic [VLEN-1:0] old = mk_old(i);
            apply(mk_instr(TBL[i].sz, 4'(i), TBL[i].imm, 5'(i + 3)), TBL[i].pr, old);
            chk(out_valid && !out_undef, "R1 valid on table entry",
                {out_valid, out_undef}, 2'b10);
            chk(result == exp_merge(old, TBL[i].pr, TBL[i].sz, TBL[i].k),
                $sformatf("R4/R5/R6/R7 entry %0d", i), result,
                exp_merge(old, TBL[i].pr, TBL[i].sz, TBL[i].k));
        end

        // R2 register fields
        apply(mk_instr(2'd2, 4'd9, 8'h70, 5'd17), '1, mk_old(40));
        chk(dst_idx == 5'd17, "R2 dst_idx", dst_idx, 17);
        chk(pred_idx == 4'd9, "R2 pred_idx", pred_idx, 9);

        // R8 pulse ends, data held
        @(negedge clk);
        chk(!out_valid, "R8 valid drops", out_valid, 0);
        chk(result == exp_merge(mk_old(40), '1, 2'd2, 64'h3F80_0000), "R8 result held",
            result, exp_merge(mk_old(40), '1, 2'd2, 64'h3F80_0000));
        chk(dst_idx == 5'd17 && pred_idx == 4'd9, "R8 indices held",
            {dst_idx, pred_idx}, {5'd17, 4'd9});

        // R3 reserved lane width
        apply(mk_instr(2'd0, 4'd2, 8'h70, 5'd4), '1, mk_old(50));
        chk(out_valid && out_undef, "R3 undef flagged", {out_valid, out_undef}, 2'b11);
        chk(result == mk_old(50), "R3 old vector kept", result, mk_old(50));

        // R1 mismatching word (bit 20 cleared)
        apply(mk_instr(2'd2, 4'd1, 8'h70, 5'd1) & ~32'h0010_0000, '1, mk_old(60));
        chk(!out_valid && !out_undef, "R1 non-matching word",
            {out_valid, out_undef}, 0);

        // R7 all-zero predicate, every lane width
        for (int s = 1; s < 4; s++) begin
            apply(mk_instr(2'(s), 4'd0, 8'hFF, 5'd2), '0, mk_old(70 + s));
            chk(out_valid && result == mk_old(70 + s), "R7 zero predicate",
                result, mk_old(70 + s));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule